// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode controller of a small microcontroller. It walks the system between four modes. In active mode everything runs. In flexible sleep only the core clock is stopped. In hibernate the core, the peripherals and the fast oscillator are off, while a chosen number of RAM banks stay powered. In shutdown almost everything is off. The block drives one enable per power or clock domain and holds the pads while they must not move. After waking from shutdown it issues a reset request and keeps the pads latched until software releases them.

Software reaches the block through a simple write port. The mode register and the retention register are protected. A write to either takes effect only when the write just before it put the power key into the key register. The wake enables and the hibernate exit latency can be written freely. Each mode has a fixed set of wake sources, and that set is further masked by the software wake enables. A wake input outside the set for the current mode does nothing. A mode request is refused when a wake source that counts for the requested mode is already asserted.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the block is in active mode (`cur_mode` 0). All domain enables are 1 and every RAM bank is enabled. `pad_hold` and `reset_req` are 0, the retention select is 0, all wake enables are 1 and the hibernate latency is `DEF_LAT`.
- R2: Register addresses: 0 = key, 1 = mode, 2 = retention, 3 = pad unlock, 4 = wake enable, 5 = wake latency. A write to address 1 or 2 takes effect only if the write immediately before it wrote 0x4859 to address 0. Any other write in between, to any address, cancels the key.
- R3: Mode code 1 (written to bits [1:0] at address 1) enters flexible sleep. There `core_clk_en` is 0 and every other enable is as in active mode. An enabled wake on bits 0–5, 10 (DMA) or 11 (timer) returns to active at the next clock edge.
- R4: Mode code 2 enters hibernate (`cur_mode` 2). In hibernate the core clock, peripheral clock and fast oscillator are off. The slow RC and crystal oscillators and both RTC enables stay on, and `pad_hold` is 1. RAM bank i is enabled exactly when i ≤ the retention select. Select 0 keeps bank 0 only, and 3 keeps all four.
- R5: Hibernate wakes on bits 0–3 (external interrupts), 4 and 5 (RTC0, RTC1), 6 (battery range) and 7 (UART receive). After the wake edge the block stays in hibernate outputs for L+1 further edges, where L is the latency register, and then returns to active.
- R6: Mode code 3 enters shutdown (`cur_mode` 3). All enables and RAM banks are 0. The exception is that `lf_xtal_en` and `rtc_en[0]` equal wake-enable bit 4. Shutdown wakes only on bits 0–2, 4 (RTC0), 8 (battery low) and 9 (external reset).
- R7: A shutdown wake asserts `reset_req` for `RST_CYC` cycles with `cur_mode` 0, then returns to active. It also clears the retention select to 0 and cancels the key. The wake enables and the latency are preserved.
- R8: `pad_hold` is 1 from shutdown entry onward. It stays 1 in active mode after the wake until 0x58FA is written to address 3. Any other value written there leaves it at 1.
- R9: A wake input whose bit is clear in the wake enables, or which is outside the current mode's set, leaves the mode unchanged.
- R10: A mode request is rejected, and the block stays active, when a wake bit that is enabled and in the requested mode's set is high in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| wake_in | input | 12 | Wake event inputs, bit layout as in R3, R5, R6 |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| hf_osc_en | output | 1 | Fast oscillator enable |
| lf_rc_en | output | 1 | Slow RC oscillator enable |
| lf_xtal_en | output | 1 | Slow crystal oscillator enable |
| ram_bank_en | output | NBANK | Per-bank RAM power enable |
| rtc_en | output | 2 | RTC0 / RTC1 enables |
| pad_hold | output | 1 | Pad state latch |
| reset_req | output | 1 | Power-on reset request after shutdown wake |
| cur_mode | output | 2 | Current mode code |

## Verification
A wrong internal mode shows at once on `cur_mode` and on the domain enables, on the edge after the faulty transition. So the bench's model, compared on every cycle, exposes any mis-sequencing within one clock. A stale key flag or retention value stays hidden until the next protected write or the next hibernate entry, so the stimulus follows every key sequence with a mode change whose outputs reveal it. Latency and reset-pulse counter errors appear as a mode change one or more edges early or late.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_ACT   = 3'd0,
      ST_FLEXI = 3'd1,
      ST_HIB   = 3'd2,
      ST_HWAKE = 3'd3,
      ST_SD    = 3'd4,
      ST_SDRST = 3'd5
   } lpm_state_e;

   localparam int WAKE_W = 12;

   localparam int WK_EXT0   = 0;
   localparam int WK_EXT1   = 1;
   localparam int WK_EXT2   = 2;
   localparam int WK_EXT3   = 3;
   localparam int WK_RTC0   = 4;
   localparam int WK_RTC1   = 5;
   localparam int WK_BATRNG = 6;
   localparam int WK_UARTRX = 7;
   localparam int WK_BATLOW = 8;
   localparam int WK_EXTRST = 9;
   localparam int WK_DMA    = 10;
   localparam int WK_TIMER  = 11;

   localparam logic [WAKE_W-1:0] MSK_FLEXI =
      (12'd1 << WK_EXT0) | (12'd1 << WK_EXT1) | (12'd1 << WK_EXT2) |
      (12'd1 << WK_EXT3) | (12'd1 << WK_RTC0) | (12'd1 << WK_RTC1) |
      (12'd1 << WK_DMA)  | (12'd1 << WK_TIMER);
   localparam logic [WAKE_W-1:0] MSK_HIB =
      (12'd1 << WK_EXT0) | (12'd1 << WK_EXT1) | (12'd1 << WK_EXT2) |
      (12'd1 << WK_EXT3) | (12'd1 << WK_RTC0) | (12'd1 << WK_RTC1) |
      (12'd1 << WK_BATRNG) | (12'd1 << WK_UARTRX);
   localparam logic [WAKE_W-1:0] MSK_SD =
      (12'd1 << WK_EXT0) | (12'd1 << WK_EXT1) | (12'd1 << WK_EXT2) |
      (12'd1 << WK_RTC0) | (12'd1 << WK_BATLOW) | (12'd1 << WK_EXTRST);

   localparam int A_KEY    = 0;
   localparam int A_MODE   = 1;
   localparam int A_RET    = 2;
   localparam int A_UNLOCK = 3;
   localparam int A_WAKEEN = 4;
   localparam int A_LAT    = 5;

   localparam logic [15:0] PWR_KEY = 16'h4859;
   localparam logic [15:0] PAD_KEY = 16'h58FA;

   localparam logic [1:0] MC_ACT   = 2'd0;
   localparam logic [1:0] MC_FLEXI = 2'd1;
   localparam logic [1:0] MC_HIB   = 2'd2;
   localparam logic [1:0] MC_SD    = 2'd3;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
   import lpm_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3,
   parameter int RET_W   = 2,
   parameter int LAT_W   = 8,
   parameter int DEF_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_cfg,
   output logic [RET_W-1:0]  ret_sel,
   output logic [WAKE_W-1:0] wake_en,
   output logic [LAT_W-1:0]  lat_val,
   output logic              mode_req,
   output logic [1:0]        mode_tgt,
   output logic              unlock_hit
);

   logic armed_q;
   logic key_hit;
   logic at_key, at_mode, at_ret, at_unlock, at_wen, at_lat;

   assign at_key    = (wr_addr == ADDR_W'(A_KEY));
   assign at_mode   = (wr_addr == ADDR_W'(A_MODE));
   assign at_ret    = (wr_addr == ADDR_W'(A_RET));
   assign at_unlock = (wr_addr == ADDR_W'(A_UNLOCK));
   assign at_wen    = (wr_addr == ADDR_W'(A_WAKEEN));
   assign at_lat    = (wr_addr == ADDR_W'(A_LAT));

   assign key_hit    = wr_en && at_key && (wr_data == DATA_W'(PWR_KEY));
   assign mode_tgt   = wr_data[1:0];
   assign mode_req   = wr_en && armed_q && at_mode && (wr_data[1:0] != MC_ACT);
   assign unlock_hit = wr_en && at_unlock && (wr_data == DATA_W'(PAD_KEY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ret_sel <= '0;
         wake_en <= '1;
         lat_val <= LAT_W'(DEF_LAT);
      end else begin
         if (clr_cfg) begin
            armed_q <= 1'b0;
            ret_sel <= '0;
         end else begin
            if (wr_en && armed_q && at_ret)
               ret_sel <= wr_data[RET_W-1:0];
            if (wr_en)
               armed_q <= key_hit;
         end
         if (wr_en && at_wen)
            wake_en <= wr_data[WAKE_W-1:0];
         if (wr_en && at_lat)
            lat_val <= wr_data[LAT_W-1:0];
      end
   end

   AST_RET_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_sel != $past(ret_sel)) |-> ($past(armed_q) || $past(clr_cfg))); // R2

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake
   import lpm_pkg::*;
(
   input  lpm_state_e        state,
   input  logic [WAKE_W-1:0] wake_in,
   input  logic [WAKE_W-1:0] wake_en,
   input  logic [1:0]        mode_tgt,
   output logic              qwake,
   output logic              pending
);

   logic [WAKE_W-1:0] cur_msk;
   logic [WAKE_W-1:0] tgt_msk;
   logic [WAKE_W-1:0] live;

   assign live = wake_in & wake_en;

   always_comb begin
      unique case (state)
         ST_FLEXI: cur_msk = MSK_FLEXI;
         ST_HIB:   cur_msk = MSK_HIB;
         ST_SD:    cur_msk = MSK_SD;
         default:  cur_msk = '0;
      endcase
   end

   always_comb begin
      unique case (mode_tgt)
         MC_FLEXI: tgt_msk = MSK_FLEXI;
         MC_HIB:   tgt_msk = MSK_HIB;
         MC_SD:    tgt_msk = MSK_SD;
         default:  tgt_msk = '0;
      endcase
   end

   assign qwake   = |(live & cur_msk);
   assign pending = |(live & tgt_msk);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
#(
   parameter int LAT_W   = 8,
   parameter int RST_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qwake,
   input  logic             mode_req,
   input  logic [1:0]       mode_tgt,
   input  logic             pending,
   input  logic             unlock_hit,
   input  logic [LAT_W-1:0] lat_val,
   output lpm_state_e       state,
   output logic             padlock
);

   lpm_state_e       state_q;
   logic [LAT_W-1:0] cnt_q;
   logic             go;

   assign state = state_q;
   assign go    = (state_q == ST_ACT) && mode_req && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ACT;
         cnt_q   <= '0;
         padlock <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ACT: begin
               if (unlock_hit)
                  padlock <= 1'b0;
               if (go) begin
                  unique case (mode_tgt)
                     MC_FLEXI: state_q <= ST_FLEXI;
                     MC_HIB:   state_q <= ST_HIB;
                     default: begin
                        state_q <= ST_SD;
                        padlock <= 1'b1;
                     end
                  endcase
               end
            end
            ST_FLEXI: if (qwake) state_q <= ST_ACT;
            ST_HIB: if (qwake) begin
               state_q <= ST_HWAKE;
               cnt_q   <= lat_val;
            end
            ST_SD: if (qwake) begin
               state_q <= ST_SDRST;
               cnt_q   <= LAT_W'(RST_CYC - 1);
            end
            ST_HWAKE, ST_SDRST: begin
               if (cnt_q == '0) state_q <= ST_ACT;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= ST_ACT;
         endcase
      end
   end

   AST_FLEXI_WAKE_1CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLEXI && qwake) |=> (state_q == ST_ACT)); // R3
   AST_HIB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HIB && !qwake) |=> (state_q == ST_HIB)); // R9
   AST_REJECT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACT && mode_req && pending) |=> (state_q == ST_ACT)); // R10

endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
   import lpm_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int RET_W = 2
) (
   input  lpm_state_e       state,
   input  logic             padlock,
   input  logic [RET_W-1:0] ret_sel,
   input  logic             rtc0_wake_en,
   output logic             core_clk_en,
   output logic             periph_clk_en,
   output logic             hf_osc_en,
   output logic             lf_rc_en,
   output logic             lf_xtal_en,
   output logic [NBANK-1:0] ram_bank_en,
   output logic [1:0]       rtc_en,
   output logic             pad_hold,
   output logic             reset_req,
   output logic [1:0]       cur_mode
);

   logic [NBANK-1:0] keep_msk;
   logic             in_hib, in_sd, in_flexi;

   genvar gi;
   generate
      for (gi = 0; gi < NBANK; gi++) begin : g_bank
         assign keep_msk[gi] = (RET_W'(gi) <= ret_sel);
      end
   endgenerate

   assign in_hib   = (state == ST_HIB) || (state == ST_HWAKE);
   assign in_sd    = (state == ST_SD);
   assign in_flexi = (state == ST_FLEXI);

   assign core_clk_en   = !(in_flexi || in_hib || in_sd);
   assign periph_clk_en = !(in_hib || in_sd);
   assign hf_osc_en     = !(in_hib || in_sd);
   assign lf_rc_en      = !in_sd;
   assign lf_xtal_en    = in_sd ? rtc0_wake_en : 1'b1;
   assign rtc_en        = in_sd ? {1'b0, rtc0_wake_en} : 2'b11;
   assign ram_bank_en   = in_sd ? '0 : (in_hib ? keep_msk : '1);
   assign pad_hold      = padlock || in_hib;
   assign reset_req     = (state == ST_SDRST);

   always_comb begin
      if (in_flexi)    cur_mode = MC_FLEXI;
      else if (in_hib) cur_mode = MC_HIB;
      else if (in_sd)  cur_mode = MC_SD;
      else             cur_mode = MC_ACT;
   end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
   import lpm_pkg::*;
#(
   parameter int NBANK   = 4,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3,
   parameter int LAT_W   = 8,
   parameter int DEF_LAT = 4,
   parameter int RST_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [11:0]       wake_in,
   output logic              core_clk_en,
   output logic              periph_clk_en,
   output logic              hf_osc_en,
   output logic              lf_rc_en,
   output logic              lf_xtal_en,
   output logic [NBANK-1:0]  ram_bank_en,
   output logic [1:0]        rtc_en,
   output logic              pad_hold,
   output logic              reset_req,
   output logic [1:0]        cur_mode
);

   localparam int RET_W = $clog2(NBANK);

   generate
      if (NBANK < 2 || (1 << RET_W) != NBANK) begin : g_bad_nbank
         $error("NBANK must be a power of two of at least 2");
      end
      if (DATA_W < 16 || DATA_W < WAKE_W || DATA_W < LAT_W) begin : g_bad_data
         $error("DATA_W too narrow for keys, wake enables or latency");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover six register addresses");
      end
      if (RST_CYC < 1 || RST_CYC > (1 << LAT_W)) begin : g_bad_rst
         $error("RST_CYC must be at least 1 and fit the counter");
      end
      if (DEF_LAT >= (1 << LAT_W)) begin : g_bad_lat
         $error("DEF_LAT does not fit LAT_W");
      end
   endgenerate

   lpm_state_e        state;
   logic              padlock;
   logic [RET_W-1:0]  ret_sel;
   logic [WAKE_W-1:0] wake_en;
   logic [LAT_W-1:0]  lat_val;
   logic              mode_req, unlock_hit, qwake, pending;
   logic [1:0]        mode_tgt;

   lpm_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RET_W(RET_W),
      .LAT_W(LAT_W), .DEF_LAT(DEF_LAT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clr_cfg(state == ST_SDRST), .ret_sel(ret_sel),
      .wake_en(wake_en), .lat_val(lat_val), .mode_req(mode_req),
      .mode_tgt(mode_tgt), .unlock_hit(unlock_hit)
   );

   lpm_wake u_wake (
      .state(state), .wake_in(wake_in), .wake_en(wake_en),
      .mode_tgt(mode_tgt), .qwake(qwake), .pending(pending)
   );

   lpm_fsm #(.LAT_W(LAT_W), .RST_CYC(RST_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .qwake(qwake), .mode_req(mode_req),
      .mode_tgt(mode_tgt), .pending(pending), .unlock_hit(unlock_hit),
      .lat_val(lat_val), .state(state), .padlock(padlock)
   );

   lpm_outdec #(.NBANK(NBANK), .RET_W(RET_W)) u_out (
      .state(state), .padlock(padlock), .ret_sel(ret_sel),
      .rtc0_wake_en(wake_en[WK_RTC0]), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .hf_osc_en(hf_osc_en),
      .lf_rc_en(lf_rc_en), .lf_xtal_en(lf_xtal_en),
      .ram_bank_en(ram_bank_en), .rtc_en(rtc_en), .pad_hold(pad_hold),
      .reset_req(reset_req), .cur_mode(cur_mode)
   );

   AST_RESET_ONLY_FROM_SD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_req) |-> ($past(cur_mode) == MC_SD)); // R7
   AST_SD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MC_SD) |-> (ram_bank_en == '0 && !core_clk_en && !hf_osc_en)); // R6
   AST_HIB_BANK0_PADS: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MC_HIB) |-> (ram_bank_en[0] && pad_hold && !periph_clk_en)); // R4
   AST_PAD_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_req) |-> pad_hold); // R8

endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;

   localparam int RSTC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [11:0] wake_in = '0;
   logic        core_clk_en, periph_clk_en, hf_osc_en, lf_rc_en, lf_xtal_en;
   logic [3:0]  ram_bank_en;
   logic [1:0]  rtc_en;
   logic        pad_hold, reset_req;
   logic [1:0]  cur_mode;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lpm_sequencer #(.RST_CYC(RSTC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wake_in(wake_in), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .hf_osc_en(hf_osc_en),
      .lf_rc_en(lf_rc_en), .lf_xtal_en(lf_xtal_en),
      .ram_bank_en(ram_bank_en), .rtc_en(rtc_en), .pad_hold(pad_hold),
      .reset_req(reset_req), .cur_mode(cur_mode)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // wake source sets per model mode: 1 flexi, 2 hibernate, 4 shutdown
   function automatic logic [11:0] msk(input int m);
      case (m)
         1: return 12'h03F | (12'd1 << 10) | (12'd1 << 11);
         2: return 12'h0FF;
         4: return 12'h007 | (12'd1 << 4) | (12'd1 << 8) | (12'd1 << 9);
         default: return 12'h000;
      endcase
   endfunction

   // reference model: 0 act, 1 flexi, 2 hib, 3 hib exit, 4 shutdown, 5 reset pulse
   int         ms, mc, nms, nmc, mlat, tgt;
   bit         marm, mpad;
   bit [1:0]   mret;
   bit [11:0]  mwen;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         ms = 0; mc = 0; marm = 0; mpad = 0; mret = 0; mwen = '1; mlat = 4;
      end else begin
         nms = ms; nmc = mc;
         case (ms)
            0: begin
               if (wr_en && wr_addr == 3 && wr_data == 16'h58FA) mpad = 0;
               if (wr_en && marm && wr_addr == 1 && wr_data[1:0] != 0) begin
                  tgt = (wr_data[1:0] == 3) ? 4 : int'(wr_data[1:0]);
                  if ((wake_in & mwen & msk(tgt)) == 0) begin
                     nms = tgt;
                     if (tgt == 4) mpad = 1;
                  end
               end
            end
            1: if ((wake_in & mwen & msk(1)) != 0) nms = 0;
            2: if ((wake_in & mwen & msk(2)) != 0) begin nms = 3; nmc = mlat; end
            4: if ((wake_in & mwen & msk(4)) != 0) begin nms = 5; nmc = RSTC - 1; end
            default: if (mc == 0) nms = 0; else nmc = mc - 1;
         endcase
         if (ms == 5) begin
            marm = 0; mret = 0;
         end else begin
            if (wr_en && marm && wr_addr == 2) mret = wr_data[1:0];
            if (wr_en) marm = (wr_addr == 0 && wr_data == 16'h4859);
         end
         if (wr_en && wr_addr == 4) mwen = wr_data[11:0];
         if (wr_en && wr_addr == 5) mlat = int'(wr_data[7:0]);
         ms = nms; mc = nmc;
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      string t;
      logic [14:0] e, a;
      logic [3:0] eram;
      if (rst_n && !done) begin
         case (ms)
            1: t = "R3"; 2: t = "R4"; 3: t = "R5"; 4: t = "R6"; 5: t = "R7";
            default: t = "R1";
         endcase
         for (int i = 0; i < 4; i++) eram[i] = (i <= int'(mret));
         case (ms)
            1:    e = {1'b0, 4'b1111, 4'hF, 2'b11, 1'b0, 2'd1};
            2, 3: e = {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, eram, 2'b11, 1'b0, 2'd2};
            4:    e = {1'b0, 1'b0, 1'b0, 1'b0, mwen[4], 4'h0, 1'b0, mwen[4], 1'b0, 2'd3};
            5:    e = {5'b11111, 4'hF, 2'b11, 1'b1, 2'd0};
            default: e = {5'b11111, 4'hF, 2'b11, 1'b0, 2'd0};
         endcase
         a = {core_clk_en, periph_clk_en, hf_osc_en, lf_rc_en, lf_xtal_en,
              ram_bank_en, rtc_en, reset_req, cur_mode};
         chk(t, 32'(a), 32'(e));
         chk("R8", 32'(pad_hold), 32'(mpad || ms == 2 || ms == 3));
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         finish_run();
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_wake(input int b);
      wake_in = 12'd1 << b;
      @(negedge clk);
      wake_in = '0;
   endtask

   localparam logic [15:0] KEY = 16'h4859;

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 mode", 32'(cur_mode), 0);
      chk("R1 enables", 32'({core_clk_en, periph_clk_en, hf_osc_en, lf_rc_en, lf_xtal_en}), 32'h1F);
      chk("R1 ram", 32'(ram_bank_en), 32'hF);
      chk("R1 pad/rst", 32'({pad_hold, reset_req}), 0);

      wr(1, 16'd1);
      chk("R2 no key", 32'(cur_mode), 0);
      wr(0, KEY); wr(4, 16'h0FFF); wr(1, 16'd1);
      chk("R2 key cancelled", 32'(cur_mode), 0);

      wr(0, KEY); wr(1, 16'd1);
      chk("R3 flexi mode", 32'(cur_mode), 1);
      chk("R3 flexi enables", 32'({core_clk_en, periph_clk_en, hf_osc_en}), 32'b011);
      wake_in = 12'd1 << 8; idle(2); wake_in = '0;
      chk("R9 batt-low ignored in flexi", 32'(cur_mode), 1);
      pulse_wake(10);
      chk("R3 dma wake one cycle", 32'(cur_mode), 0);
      chk("R3 core back", 32'(core_clk_en), 1);

      wr(5, 16'd3); wr(0, KEY); wr(2, 16'd2); wr(0, KEY); wr(1, 16'd2);
      chk("R4 hib mode", 32'(cur_mode), 2);
      chk("R4 banks sel2", 32'(ram_bank_en), 32'b0111);
      chk("R4 osc", 32'({periph_clk_en, hf_osc_en, lf_rc_en, lf_xtal_en}), 32'b0011);
      wake_in = 12'd1 << 10; idle(2); wake_in = '0;
      chk("R9 dma ignored in hib", 32'(cur_mode), 2);
      pulse_wake(7);
      idle(3);
      chk("R5 latency not yet", 32'(cur_mode), 2);
      idle(1);
      chk("R5 active after L+1", 32'(cur_mode), 0);

      wake_in = 12'd1; wr(0, KEY); wr(1, 16'd2); wake_in = '0;
      chk("R10 rejected", 32'(cur_mode), 0);
      wake_in = 12'd1 << 7; wr(0, KEY); wr(1, 16'd1); wake_in = '0;
      chk("R10 uart not pending for flexi", 32'(cur_mode), 1);
      pulse_wake(0);
      chk("R3 ext0 wake", 32'(cur_mode), 0);

      wr(0, KEY); wr(1, 16'd3);
      chk("R6 sd mode", 32'(cur_mode), 3);
      chk("R6 sd ram", 32'(ram_bank_en), 0);
      chk("R6 sd rtc", 32'({rtc_en, lf_xtal_en, hf_osc_en, lf_rc_en}), 32'b01100);
      chk("R8 pads held", 32'(pad_hold), 1);
      wake_in = 12'd1 << 3; idle(2); wake_in = '0;
      chk("R6 ext3 ignored in sd", 32'(cur_mode), 3);
      pulse_wake(9);
      chk("R7 reset req", 32'(reset_req), 1);
      idle(RSTC - 1);
      chk("R7 reset req held", 32'(reset_req), 1);
      idle(1);
      chk("R7 reset done", 32'({reset_req, cur_mode}), 0);
      chk("R8 pads still latched", 32'(pad_hold), 1);
      wr(3, 16'h1234);
      chk("R8 wrong unlock", 32'(pad_hold), 1);
      wr(3, 16'h58FA);
      chk("R8 unlocked", 32'(pad_hold), 0);

      wr(0, KEY); wr(1, 16'd2);
      chk("R7 retention default", 32'(ram_bank_en), 32'b0001);
      pulse_wake(5);
      idle(4);
      chk("R5 rtc1 wake, latency kept", 32'(cur_mode), 0);

      wr(4, 16'h0FEF); wr(0, KEY); wr(1, 16'd3);
      chk("R6 rtc0 off when not enabled", 32'({rtc_en, lf_xtal_en}), 0);
      wake_in = 12'd1 << 4; idle(2); wake_in = '0;
      chk("R9 disabled rtc0 ignored", 32'(cur_mode), 3);
      pulse_wake(0);
      idle(RSTC);
      chk("R7 back active", 32'(cur_mode), 0);
      wr(3, 16'h58FA);
      wr(0, KEY); wr(1, 16'd3);
      chk("R7 wake enables preserved", 32'(rtc_en), 0);
      pulse_wake(8);
      idle(RSTC + 1);
      chk("R6 batt-low wake", 32'(cur_mode), 0);

      finish_run();
   end

endmodule